// File: doc/BRIEF.md
# Subtract-and-Branch Single-Instruction Processor Core

This core executes one instruction only: it subtracts the byte stored at operand address A from the byte stored at operand address B, stores the difference back at B, and jumps to target C when that difference is zero or negative. Code and data share one external byte-wide memory of 256 locations. Each instruction is three consecutive bytes in the order A address, B address, C target. There is no opcode and no decode stage. The core walks a fixed six-step sequence, and each step makes exactly one memory access.

The core holds a program counter and four working registers: operand A, the B address, operand B and the branch target. The memory read port is combinational, so the core samples the read data at the end of the same step that presents the address. While `run` is high the sequence advances one step per clock. A taken branch to the all-ones address stops the core until the next reset, and the core reports this on `halted`.

Top module: `subneg_core`

## Requirements
- R1: Synchronous active-high reset clears the program counter and all working registers to zero, puts the sequencer at its first step and clears `halted`. After reset the first address presented is 0x00 and `mem_we` is low.
- R2: For an instruction at PC the six steps present these addresses in order: PC, A, PC+1, B, PC+2, B. Here A is the byte read at PC and B is the byte read at PC+1.
- R3: Each step makes one access. `mem_we` is high only in the sixth step, so it is never high in two consecutive cycles.
- R4: In the sixth step `mem_wdata` carries mem[B] minus mem[A], taken modulo 256 as 8-bit two's complement. The value is written to address B.
- R5: If the difference has bit 7 set or equals zero, the next instruction is fetched from the target byte C.
- R6: If the difference is positive (bit 7 clear and nonzero), the next instruction is fetched from PC+3, whatever the value of C.
- R7: While `run` is low the sequencer holds its step, the address output stays steady and `mem_we` stays low.
- R8: A taken branch whose target is 0xFF sets `halted`. `halted` stays set until reset, and no further write occurs even while `run` is high.
- R9: Subtraction overflow wraps silently. For example, 0x7F minus 0xFF gives 0x80, which counts as negative and takes the branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Advance the step sequence while high |
| mem_addr | output | 8 | Memory address for the current step |
| mem_rdata | input | 8 | Combinational read data for `mem_addr` |
| mem_wdata | output | 8 | Write data (the difference) |
| mem_we | output | 1 | Write strobe, high in the sixth step only |
| halted | output | 1 | Sticky stop flag set by a taken branch to 0xFF |

## Verification
The bench compares every memory access against an independent model, step by step. A core that reorders the operand fetches or forgets to advance PC therefore shows up at once as a wrong address. The test programs produce a positive result with a decoy target, a zero result and a negative result. A branch test that used the carry, or ignored the zero case, would send execution to the wrong place. An overflow case, 127 minus -1, catches a core that takes the branch decision from a widened or saturated difference rather than the wrapped 8-bit one. Pausing `run` in the middle of an instruction exposes a core that keeps stepping or writes while it is paused. Running on after the halt exposes a halt flag that is not sticky.

// File: rtl/subneg_pkg.sv
package subneg_pkg;

    parameter int unsigned WORD_W = 8;
    localparam int unsigned MEM_DEPTH = 1 << WORD_W;

    typedef logic [WORD_W-1:0] word_t;

    localparam word_t STOP_TARGET = '1;

    typedef enum logic [2:0] {
        PH_FETCH_A  = 3'd0,
        PH_LOAD_A   = 3'd1,
        PH_FETCH_B  = 3'd2,
        PH_LOAD_B   = 3'd3,
        PH_SUB_TGT  = 3'd4,
        PH_STORE    = 3'd5
    } phase_e;

    typedef struct packed {
        word_t pc;
        word_t opa;
        word_t baddr;
        word_t opb;
        word_t tgt;
    } core_state_t;

    function automatic logic is_nonpositive(word_t v);
        return v[WORD_W-1] | (v == '0);
    endfunction

    function automatic phase_e phase_after(phase_e p);
        case (p)
            PH_FETCH_A: return PH_LOAD_A;
            PH_LOAD_A:  return PH_FETCH_B;
            PH_FETCH_B: return PH_LOAD_B;
            PH_LOAD_B:  return PH_SUB_TGT;
            PH_SUB_TGT: return PH_STORE;
            default:    return PH_FETCH_A;
        endcase
    endfunction

endpackage

// File: rtl/subneg_sequencer.sv
module subneg_sequencer
    import subneg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   run,
    input  logic   stop_req,
    output phase_e phase,
    output logic   go,
    output logic   halted
);

    assign go = run & ~halted;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_FETCH_A;
            halted <= 1'b0;
        end else if (go) begin
            phase <= phase_after(phase);
            if (stop_req) begin
                halted <= 1'b1;
            end
        end
    end

    assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    assert_pause_holds_R7: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(phase));

    assert_store_wraps_R3: assert property (@(posedge clk) disable iff (rst)
        (go && phase == PH_STORE) |=> (phase == PH_FETCH_A));

endmodule

// File: rtl/subneg_datapath.sv
module subneg_datapath
    import subneg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        go,
    input  phase_e      phase,
    input  word_t       rdata,
    output core_state_t st,
    output logic        stop_req
);

    logic take_branch;

    assign take_branch = (phase == PH_STORE) && is_nonpositive(st.opb);
    assign stop_req    = take_branch && (st.tgt == STOP_TARGET);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (go) begin
            case (phase)
                PH_FETCH_A: begin
                    st.opa <= rdata;
                    st.pc  <= st.pc + word_t'(1);
                end
                PH_LOAD_A: begin
                    st.opa <= rdata;
                end
                PH_FETCH_B: begin
                    st.baddr <= rdata;
                    st.pc    <= st.pc + word_t'(1);
                end
                PH_LOAD_B: begin
                    st.opb <= rdata;
                end
                PH_SUB_TGT: begin
                    st.opb <= st.opb - st.opa;
                    st.tgt <= rdata;
                    st.pc  <= st.pc + word_t'(1);
                end
                PH_STORE: begin
                    if (take_branch) begin
                        st.pc <= st.tgt;
                    end
                end
                default: ;
            endcase
        end
    end

    assert_pc_advance_R2: assert property (@(posedge clk) disable iff (rst)
        (go && phase == PH_FETCH_A) |=> (st.pc == $past(st.pc) + word_t'(1)));

    assert_difference_R4: assert property (@(posedge clk) disable iff (rst)
        (go && phase == PH_SUB_TGT) |=> (st.opb == $past(st.opb) - $past(st.opa)));

    assert_branch_taken_R5: assert property (@(posedge clk) disable iff (rst)
        (go && phase == PH_STORE && is_nonpositive(st.opb)) |=> (st.pc == $past(st.tgt)));

    assert_fall_through_R6: assert property (@(posedge clk) disable iff (rst)
        (go && phase == PH_STORE && !is_nonpositive(st.opb)) |=> $stable(st.pc));

endmodule

// File: rtl/subneg_bus.sv
module subneg_bus
    import subneg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        go,
    input  logic        halted,
    input  phase_e      phase,
    input  core_state_t st,
    output word_t       addr,
    output word_t       wdata,
    output logic        we
);

    always_comb begin
        case (phase)
            PH_FETCH_A, PH_FETCH_B, PH_SUB_TGT: addr = st.pc;
            PH_LOAD_A:                          addr = st.opa;
            default:                            addr = st.baddr;
        endcase
    end

    assign wdata = st.opb;
    assign we    = go && (phase == PH_STORE);

    assert_single_write_R3: assert property (@(posedge clk) disable iff (rst)
        we |=> !we);

    assert_quiet_when_halted_R8: assert property (@(posedge clk) disable iff (rst)
        halted |-> !we);

endmodule

// File: rtl/subneg_core.sv
module subneg_core
    import subneg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    output logic [WORD_W-1:0]   mem_addr,
    input  logic [WORD_W-1:0]   mem_rdata,
    output logic [WORD_W-1:0]   mem_wdata,
    output logic                mem_we,
    output logic                halted
);

    phase_e      phase;
    logic        go;
    logic        stop_req;
    core_state_t st;

    subneg_sequencer u_seq (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .stop_req (stop_req),
        .phase    (phase),
        .go       (go),
        .halted   (halted)
    );

    subneg_datapath u_dp (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .phase    (phase),
        .rdata    (mem_rdata),
        .st       (st),
        .stop_req (stop_req)
    );

    subneg_bus u_bus (
        .clk    (clk),
        .rst    (rst),
        .go     (go),
        .halted (halted),
        .phase  (phase),
        .st     (st),
        .addr   (mem_addr),
        .wdata  (mem_wdata),
        .we     (mem_we)
    );

endmodule

// File: tb/subneg_core_bench.sv
`timescale 1ns/1ps
module subneg_core_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run = 1'b0;
    logic [7:0] mem_addr;
    logic [7:0] mem_rdata;
    logic [7:0] mem_wdata;
    logic       mem_we;
    logic       halted;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    bit active = 1'b0;

    logic [7:0] mem     [256];
    logic [7:0] ref_mem [256];

    typedef struct {
        logic [7:0] addr;
        logic       we;
        logic [7:0] wdata;
        string      tag;
    } access_t;

    access_t expq[$];
    access_t cur;
    bit         frozen_prev = 1'b0;
    logic [7:0] frozen_addr = 8'h00;

    always #2.5 clk = ~clk;

    subneg_core u_subneg_core (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .halted    (halted)
    );

    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
        end
    endtask

    // Driver: reference model of the instruction pushes expected accesses
    task automatic push_reference();
        logic [7:0] pc;
        logic [7:0] a, b, c, res;
        bit stop;
        pc   = 8'h00;
        stop = 1'b0;
        for (int n = 0; n < 400 && !stop; n++) begin
            a = ref_mem[pc];
            b = ref_mem[pc + 8'd1];
            c = ref_mem[pc + 8'd2];
            res = ref_mem[b] - ref_mem[a];
            expq.push_back('{pc,          1'b0, 8'h00, "R5 R6 next-PC"});
            expq.push_back('{a,           1'b0, 8'h00, "R2 A-read"});
            expq.push_back('{pc + 8'd1,   1'b0, 8'h00, "R2 B-fetch"});
            expq.push_back('{b,           1'b0, 8'h00, "R2 B-read"});
            expq.push_back('{pc + 8'd2,   1'b0, 8'h00, "R2 C-fetch"});
            expq.push_back('{b,           1'b1, res,   "R4 store"});
            ref_mem[b] = res;
            if (res[7] || res == 8'h00) begin
                pc = c;
                if (c == 8'hFF) stop = 1'b1;
            end else begin
                pc = pc + 8'd3;
            end
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'h00;
        end
    endtask

    task automatic snapshot();
        for (int i = 0; i < 256; i++) begin
            ref_mem[i] = mem[i];
        end
    endtask

    task automatic wait_drained();
        while (expq.size() > 0) @(posedge clk);
        repeat (12) @(posedge clk);
    endtask

    task automatic compare_memory(input string tag);
        for (int i = 0; i < 256; i++) begin
            chk(mem[i] === ref_mem[i], tag, $sformatf("final mem[%02h]", i), mem[i], ref_mem[i]);
        end
    endtask

    // Monitor: pops expected accesses as the core produces them
    always @(negedge clk) begin
        if (!rst && active) begin
            if (run) begin
                frozen_prev = 1'b0;
                if (expq.size() > 0) begin
                    cur = expq.pop_front();
                    chk(mem_addr === cur.addr, cur.tag, "address", mem_addr, cur.addr);
                    chk(mem_we === cur.we, "R3", "write enable", {7'd0, mem_we}, {7'd0, cur.we});
                    if (cur.we) begin
                        chk(mem_wdata === cur.wdata, cur.tag, "write data", mem_wdata, cur.wdata);
                    end
                end else begin
                    chk(halted === 1'b1, "R8", "halted after stop", {7'd0, halted}, 8'd1);
                    chk(mem_we === 1'b0, "R8", "no write after stop", {7'd0, mem_we}, 8'd0);
                end
            end else begin
                chk(mem_we === 1'b0, "R7", "write while paused", {7'd0, mem_we}, 8'd0);
                if (frozen_prev) begin
                    chk(mem_addr === frozen_addr, "R7", "address while paused", mem_addr, frozen_addr);
                end
                frozen_prev = 1'b1;
                frozen_addr = mem_addr;
            end
        end
    end

    initial begin
        // Program 1: counting loop (N at 0x40 counts 5 down, ACC at 0x43 gains 2 per pass)
        clear_mem();
        mem[8'h00] = 8'h44; mem[8'h01] = 8'h43; mem[8'h02] = 8'h20; // ACC -= -2, positive: decoy target
        mem[8'h03] = 8'h41; mem[8'h04] = 8'h40; mem[8'h05] = 8'hFF; // N -= 1, <=0 stops
        mem[8'h06] = 8'h42; mem[8'h07] = 8'h42; mem[8'h08] = 8'h00; // Z -= Z, zero: jump to 0
        mem[8'h40] = 8'd5;  mem[8'h41] = 8'd1;  mem[8'h42] = 8'd0;
        mem[8'h43] = 8'd0;  mem[8'h44] = 8'hFE;
        snapshot();
        push_reference();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(mem_addr === 8'h00, "R1", "reset address", mem_addr, 8'h00);
        chk(mem_we === 1'b0, "R1", "reset write enable", {7'd0, mem_we}, 8'd0);
        chk(halted === 1'b0, "R1", "reset halted", {7'd0, halted}, 8'd0);
        @(posedge clk);
        #1 active = 1'b1; run = 1'b1;
        repeat (40) @(posedge clk);
        #1 run = 1'b0;
        repeat (7) @(posedge clk);
        #1 run = 1'b1;
        repeat (23) @(posedge clk);
        #1 run = 1'b0;
        repeat (3) @(posedge clk);
        #1 run = 1'b1;
        wait_drained();
        chk(halted === 1'b1, "R8", "halted at end of loop", {7'd0, halted}, 8'd1);
        chk(mem[8'h43] === 8'd10, "R6", "accumulator after loop", mem[8'h43], 8'd10);
        chk(mem[8'h40] === 8'd0, "R5", "counter after loop", mem[8'h40], 8'd0);
        compare_memory("R4");

        // Program 2: overflow 0x7F - 0xFF wraps to 0x80, branches to 0x09, then stops
        #1 rst = 1'b1; active = 1'b0; run = 1'b0;
        clear_mem();
        mem[8'h00] = 8'h41; mem[8'h01] = 8'h40; mem[8'h02] = 8'h09;
        mem[8'h09] = 8'h42; mem[8'h0A] = 8'h42; mem[8'h0B] = 8'hFF;
        mem[8'h40] = 8'h7F; mem[8'h41] = 8'hFF;
        snapshot();
        push_reference();
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(halted === 1'b0, "R1", "halted cleared by reset", {7'd0, halted}, 8'd0);
        chk(mem_addr === 8'h00, "R1", "address after second reset", mem_addr, 8'h00);
        @(posedge clk);
        #1 active = 1'b1; run = 1'b1;
        wait_drained();
        chk(mem[8'h40] === 8'h80, "R9", "wrapped difference", mem[8'h40], 8'h80);
        chk(halted === 1'b1, "R8", "halted after overflow program", {7'd0, halted}, 8'd1);
        compare_memory("R9");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL R8 watchdog expired before stop actual=%0d expected=%0d", halted, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule